// File: doc/BRIEF.md
# Match-Channel Timer With Watchdog Reset

A memory-mapped timer built around one free-running up-counter that advances once per microsecond tick. The tick is derived from the system clock by a prescaler. Several compare channels each hold a match value and raise a sticky interrupt flag on the tick where the counter arrives at that value. The interrupt output is the OR of the flags whose enable bits are set.

One compare channel doubles as a watchdog. There is no separate down-counter. Software keeps the system alive by latching the counter, adding a timeout in ticks, and writing the sum into that channel's match register. A chip reset pulse is produced only when the channel's interrupt enable bit and the watchdog enable are both set at the moment of the match.

Remaining time is read as match minus counter. The counter wraps modulo its width, so this difference stays valid across a wrap. A snapshot latch gives software a consistent copy of the counter.

Top module: `mtimer_wdog`

## Requirements
- R1: After a synchronous reset, the counter, all match registers, the status flags, the interrupt enables, the watchdog enable, the latched copy, `irq` and `wdog_rst` are all zero.
- R2: The counter at offset 0x00 increments by one every PRESCALE clocks and wraps modulo 2^CNT_W. Writes to 0x00 leave it unchanged.
- R3: Writing a value with bit 0 set to offset 0x30 copies the counter value held before that clock edge into the latched register at 0x34. The latched register keeps that value until the next such write. A write to 0x30 with bit 0 clear has no effect, and 0x30 reads as zero.
- R4: The match register of channel n is at 0x08 + 4·n. It is readable and writable, zero-extended to 32 bits.
- R5: Status bit n (offset 0x2C, bits [NUM_CH-1:0]) is set on the tick where the counter becomes equal to match n. The bit stays set until a write to 0x2C with a 1 in bit n clears it.
- R6: Writing a match value equal to the current counter does not set the status bit. The bit is set only once the counter later steps onto that value.
- R7: `irq` is high exactly when some status bit is set and its enable bit in the mask at 0x24 (bits [NUM_CH-1:0]) is also set.
- R8: When the watchdog channel (index WDOG_CH, default 5) matches while interrupt-enable bit WDOG_CH and watchdog enable bit 0 at 0x28 are both set, `wdog_rst` goes high from that clock edge for exactly RST_PULSE clocks.
- R9: If either of the two enables is clear at the moment of the match, `wdog_rst` stays low. This includes the case where both were cleared after being set.
- R10: Reads from undefined word offsets (for example 0x04, 0x20, 0x38) return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per clock |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: enabled status flags ORed |
| wdog_rst | output | 1 | Watchdog reset pulse, RST_PULSE clocks long |

## Verification
A wrong counter or prescaler state shows at offset 0x00 at the very next sample, because the bench predicts the count from the number of clock edges since reset. A corrupted match, status or enable bit shows within one tick of the predicted match: the status flag, `irq` or `wdog_rst` appears one sample early, one sample late, or not at all. A wrong pulse counter shows as a reset pulse of the wrong length, measured clock by clock. A small counter width lets the sweep pass through a full wrap, so carry and compare errors at the top of the range also appear.

// File: rtl/mtw_pkg.sv
// Package mtw_pkg
// Shared word offsets of the timer register space.
// Assumes byte addressing with one 32-bit word per 4 bytes.
package mtw_pkg;
    localparam int OFF_COUNT   = 'h00;
    localparam int OFF_MATCH0  = 'h08;
    localparam int OFF_INT_EN  = 'h24;
    localparam int OFF_WDOG_EN = 'h28;
    localparam int OFF_STATUS  = 'h2C;
    localparam int OFF_SNAP    = 'h30;
    localparam int OFF_SNAPVAL = 'h34;
    localparam int BUS_W       = 32;
endpackage

// File: rtl/mtw_prescaler.sv
// Module mtw_prescaler
// Emits a one-clock tick every PRESCALE clocks, the first after PRESCALE
// clocks out of reset. Assumes PRESCALE >= 1; a value of 1 ticks every clock.
module mtw_prescaler #(
    parameter int PRESCALE = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(PRESCALE);
            localparam logic [DIV_W-1:0] LAST = DIV_W'(PRESCALE - 1);
            logic [DIV_W-1:0] div_q;

            // Divider phase: counts 0..PRESCALE-1 and wraps
            always_ff @(posedge clk) begin
                if (!rst_n)            div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                   div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/mtw_counter.sv
// Module mtw_counter
// Free-running wrap-around up-counter with a snapshot register.
// Assumes snap_req is a single-clock strobe; the snapshot takes the
// value held before the edge, so it never sees a half-updated count.
module mtw_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             snap_req,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc,
    output logic [CNT_W-1:0] snap_q
);
    assign cnt_inc = cnt_q + 1'b1;

    // Count step: advance by one per tick, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_inc;
    end

    // Snapshot: capture current count on request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)        snap_q <= '0;
        else if (snap_req) snap_q <= cnt_q;
    end
endmodule

// File: rtl/mtw_match_bank.sv
// Module mtw_match_bank
// NUM_CH compare channels. Each holds a match value and a sticky status
// bit set on the tick where the counter steps onto that value.
// Assumes cnt_inc is the value the counter takes on this tick. Comparing
// against the step target means that loading a match equal to the
// present count cannot fire until the counter comes round to it again.
module mtw_match_bank #(
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [CNT_W-1:0]              cnt_inc,
    input  logic [NUM_CH-1:0]             load,
    input  logic [CNT_W-1:0]              load_val,
    input  logic [NUM_CH-1:0]             clr_mask,
    output logic [NUM_CH-1:0][CNT_W-1:0]  match_q,
    output logic [NUM_CH-1:0]             status_q,
    output logic [NUM_CH-1:0]             hit
);
    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            // Match register: loaded by a bus write to this channel
            always_ff @(posedge clk) begin
                if (!rst_n)        match_q[ch] <= '0;
                else if (load[ch]) match_q[ch] <= load_val;
            end

            assign hit[ch] = tick && (cnt_inc == match_q[ch]);

            // Sticky flag: a new hit wins over a clear in the same cycle
            always_ff @(posedge clk) begin
                if (!rst_n)            status_q[ch] <= 1'b0;
                else if (hit[ch])      status_q[ch] <= 1'b1;
                else if (clr_mask[ch]) status_q[ch] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/mtw_reset_pulse.sv
// Module mtw_reset_pulse
// Stretches a single-clock fire strobe into a reset pulse RST_PULSE clocks
// long. Assumes RST_PULSE >= 1. A fire during a running pulse is ignored.
module mtw_reset_pulse #(
    parameter int RST_PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic rst_out
);
    localparam int PC_W = $clog2(RST_PULSE + 1);
    logic [PC_W-1:0] left_q;

    // Pulse length counter: load on fire when idle, then count down
    always_ff @(posedge clk) begin
        if (!rst_n)                     left_q <= '0;
        else if (fire && left_q == '0)  left_q <= PC_W'(RST_PULSE);
        else if (left_q != '0)          left_q <= left_q - 1'b1;
    end

    assign rst_out = (left_q != '0);
endmodule

// File: rtl/mtimer_wdog.sv
// Module mtimer_wdog
// Timer with NUM_CH compare channels on one free-running counter. Channel
// WDOG_CH doubles as a watchdog whose match drives a reset pulse when both
// its interrupt enable and the watchdog enable are set.
// Assumes single-cycle word writes and combinational reads, and that the
// match channels end below the interrupt-enable word (NUM_CH <= 7).
module mtimer_wdog
    import mtw_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int NUM_CH    = 6,
    parameter int WDOG_CH   = 5,
    parameter int PRESCALE  = 50,
    parameter int RST_PULSE = 16,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              wdog_rst
);
    localparam int PAD_CNT = BUS_W - CNT_W;
    localparam int PAD_CH  = BUS_W - NUM_CH;

    logic                         tick;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             cnt_inc;
    logic [CNT_W-1:0]             latched_q;
    logic [NUM_CH-1:0][CNT_W-1:0] match_q;
    logic [NUM_CH-1:0]            status_q;
    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0]            match_load;
    logic [NUM_CH-1:0]            clr_mask;
    logic [NUM_CH-1:0]            int_en_q;
    logic                         wdog_en_q;
    logic                         snap_req;
    logic                         wr_int_en;
    logic                         wr_wdog_en;
    logic                         fire;

    // Write decode for the fixed registers
    assign wr_int_en  = bus_we && (bus_addr == ADDR_W'(OFF_INT_EN));
    assign wr_wdog_en = bus_we && (bus_addr == ADDR_W'(OFF_WDOG_EN));
    assign snap_req   = bus_we && (bus_addr == ADDR_W'(OFF_SNAP)) && bus_wdata[0];
    assign clr_mask   = (bus_we && (bus_addr == ADDR_W'(OFF_STATUS)))
                        ? bus_wdata[NUM_CH-1:0] : '0;

    // Write decode for the match channels
    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
            assign match_load[ch] = bus_we &&
                (bus_addr == ADDR_W'(OFF_MATCH0 + 4 * ch));
        end
    endgenerate

    mtw_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    mtw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .snap_req (snap_req),
        .cnt_q    (cnt_q),
        .cnt_inc  (cnt_inc),
        .snap_q   (latched_q)
    );

    mtw_match_bank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_inc  (cnt_inc),
        .load     (match_load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .clr_mask (clr_mask),
        .match_q  (match_q),
        .status_q (status_q),
        .hit      (hit)
    );

    // Interrupt-enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)         int_en_q <= '0;
        else if (wr_int_en) int_en_q <= bus_wdata[NUM_CH-1:0];
    end

    // Watchdog enable register
    always_ff @(posedge clk) begin
        if (!rst_n)          wdog_en_q <= 1'b0;
        else if (wr_wdog_en) wdog_en_q <= bus_wdata[0];
    end

    assign fire = hit[WDOG_CH] && int_en_q[WDOG_CH] && wdog_en_q;

    mtw_reset_pulse #(.RST_PULSE(RST_PULSE)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .rst_out (wdog_rst)
    );

    assign irq = |(status_q & int_en_q);

    // Read multiplexer; undefined offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_COUNT))        bus_rdata = {{PAD_CNT{1'b0}}, cnt_q};
        else if (bus_addr == ADDR_W'(OFF_INT_EN))  bus_rdata = {{PAD_CH{1'b0}}, int_en_q};
        else if (bus_addr == ADDR_W'(OFF_WDOG_EN)) bus_rdata = {31'd0, wdog_en_q};
        else if (bus_addr == ADDR_W'(OFF_STATUS))  bus_rdata = {{PAD_CH{1'b0}}, status_q};
        else if (bus_addr == ADDR_W'(OFF_SNAPVAL)) bus_rdata = {{PAD_CNT{1'b0}}, latched_q};
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (bus_addr == ADDR_W'(OFF_MATCH0 + 4 * ch))
                bus_rdata = {{PAD_CNT{1'b0}}, match_q[ch]};
        end
    end
endmodule

// File: rtl/mtw_checker.sv
// Module mtw_checker
// Temporal properties of mtimer_wdog, attached by bind to every instance.
// Assumes the same parameters as the bound instance.
module mtw_checker
    import mtw_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int NUM_CH    = 6,
    parameter int WDOG_CH   = 5,
    parameter int RST_PULSE = 16,
    parameter int ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              wdog_rst,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  latched,
    input logic [NUM_CH-1:0] status,
    input logic [NUM_CH-1:0] int_en,
    input logic              wdog_en
);
    localparam int HL_W = $clog2(RST_PULSE + 2) + 1;
    logic [HL_W-1:0] high_len;

    // Length of the current run of wdog_rst high
    always_ff @(posedge clk) begin
        if (!rst_n)        high_len <= '0;
        else if (wdog_rst) high_len <= high_len + 1'b1;
        else               high_len <= '0;
    end

    logic snap_wr;
    logic stat_wr;
    assign snap_wr = bus_we && (bus_addr == ADDR_W'(OFF_SNAP));
    assign stat_wr = bus_we && (bus_addr == ADDR_W'(OFF_STATUS));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_wr |=> $stable(latched));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((status & $past(status)) == $past(status)));

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    p_fire_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> $past(int_en[WDOG_CH] && wdog_en));

    p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> (high_len < HL_W'(RST_PULSE)));
endmodule

bind mtimer_wdog mtw_checker #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .WDOG_CH(WDOG_CH),
    .RST_PULSE(RST_PULSE), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .wdog_rst(wdog_rst),
    .cnt(cnt_q), .latched(latched_q), .status(status_q),
    .int_en(int_en_q), .wdog_en(wdog_en_q)
);

// File: tb/mtimer_wdog_test.sv
module mtimer_wdog_test;
    localparam int W   = 8;
    localparam int P   = 2;
    localparam int NCH = 6;
    localparam int WD  = 5;
    localparam int RP  = 6;
    localparam int MOD = 1 << W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wdog_rst;

    int errors = 0;
    int checks = 0;
    int edges = 0;
    bit done = 0;

    mtimer_wdog #(.CNT_W(W), .NUM_CH(NCH), .WDOG_CH(WD), .PRESCALE(P),
                  .RST_PULSE(RP), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .wdog_rst(wdog_rst)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    function automatic int exp_cnt();
        return (edges / P) % MOD;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Wait for watch-channel match at value m; check flag and reset timing
    task automatic watch_match(input int ch, input int m, input bit expect_rst);
        logic [31:0] v;
        int guard = 0;
        while (exp_cnt() != m && guard < 4 * MOD) begin
            rd(8'h2C, v);
            check("R5 no early flag", {31'd0, v[ch]}, 0);
            if (ch == WD) check("R8 no early reset", {31'd0, wdog_rst}, 0);
            @(negedge clk);
            guard++;
        end
        rd(8'h2C, v);
        check("R5 flag on match", {31'd0, v[ch]}, 1);
        if (ch == WD) check(expect_rst ? "R8 reset on match" : "R9 reset gated",
                            {31'd0, wdog_rst}, {31'd0, expect_rst});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int c, m, len;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(8'h00, v); check("R1 counter", v, 0);
        rd(8'h24, v); check("R1 int_en", v, 0);
        rd(8'h28, v); check("R1 wdog_en", v, 0);
        rd(8'h2C, v); check("R1 status", v, 0);
        rd(8'h34, v); check("R1 latched", v, 0);
        for (int i = 0; i < NCH; i++) begin
            rd(8'(8 + 4 * i), v); check("R1 match", v, 0);
        end
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 wdog_rst", {31'd0, wdog_rst}, 0);
        rst_n = 1'b1;

        // R2: counter sweep through more than one wrap
        for (int i = 0; i < 2 * P * MOD + 20; i++) begin
            @(negedge clk);
            rd(8'h00, v);
            check("R2 count", v, exp_cnt());
        end
        wr(8'h00, 32'hA5);
        rd(8'h00, v); check("R2 write ignored", v, exp_cnt());

        // R3: snapshot
        c = exp_cnt();
        wr(8'h30, 1);
        rd(8'h34, v); check("R3 snapshot", v, c);
        repeat (9) @(negedge clk);
        wr(8'h30, 0);
        rd(8'h34, v); check("R3 hold", v, c);
        rd(8'h30, v); check("R3 cmd reads zero", v, 0);

        // R4/R5: every channel matches at its own value, wrap included
        for (int ch = 0; ch < NCH; ch++) begin
            c = exp_cnt();
            m = (c + 5 + ch) % MOD;
            wr(8'(8 + 4 * ch), m);
            rd(8'(8 + 4 * ch), v); check("R4 match readback", v, m);
            wr(8'h2C, 32'h3F);
            watch_match(ch, m, 1'b0);
        end
        // match across the counter wrap
        while (exp_cnt() < MOD - 3) @(negedge clk);
        m = (exp_cnt() + 6) % MOD;
        wr(8'h08, m);
        wr(8'h2C, 32'h01);
        watch_match(0, m, 1'b0);

        // R7: irq gating and W1C
        wr(8'h24, 0);
        check("R7 irq masked", {31'd0, irq}, 0);
        wr(8'h24, 32'h01);
        check("R7 irq enabled", {31'd0, irq}, 1);
        wr(8'h2C, 32'h01);
        rd(8'h2C, v); check("R5 w1c clears", {31'd0, v[0]}, 0);
        check("R7 irq after clear", {31'd0, irq}, 0);

        // R6: match equal to present count must not fire
        wr(8'h08, exp_cnt());
        wr(8'h2C, 32'h01);
        repeat (40) @(negedge clk);
        rd(8'h2C, v); check("R6 no spurious", {31'd0, v[0]}, 0);
        check("R6 irq stays low", {31'd0, irq}, 0);

        // R10: undefined offsets
        wr(8'h24, 32'h05);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h04, v); check("R10 read 04", v, 0);
        rd(8'h20, v); check("R10 read 20", v, 0);
        rd(8'h38, v); check("R10 read 38", v, 0);
        rd(8'h24, v); check("R10 int_en kept", v, 5);
        rd(8'h28, v); check("R10 wdog_en kept", v, 0);

        // R9: only the watchdog enable set
        wr(8'h24, 0);
        wr(8'h28, 1);
        wr(8'h2C, 32'h3F);
        m = (exp_cnt() + 6) % MOD;
        wr(8'h1C, m);
        watch_match(WD, m, 1'b0);
        repeat (4) begin @(negedge clk); check("R9 stays low", {31'd0, wdog_rst}, 0); end

        // R9: only the channel interrupt enable set
        wr(8'h28, 0);
        wr(8'h24, 32'h20);
        wr(8'h2C, 32'h3F);
        m = (exp_cnt() + 6) % MOD;
        wr(8'h1C, m);
        watch_match(WD, m, 1'b0);
        repeat (4) begin @(negedge clk); check("R9 stays low", {31'd0, wdog_rst}, 0); end

        // R8: both set, refresh once, then fire; pulse length
        wr(8'h28, 1);
        wr(8'h2C, 32'h3F);
        wr(8'h30, 1);
        rd(8'h34, v);
        m = (v + 30) % MOD;
        wr(8'h1C, m);
        repeat (10) @(negedge clk);
        wr(8'h30, 1);
        rd(8'h34, v);
        m = (v + 12) % MOD;
        wr(8'h1C, m);
        watch_match(WD, m, 1'b1);
        len = 0;
        while (wdog_rst && len < 4 * RP) begin len++; @(negedge clk); end
        check("R8 pulse length", len, RP);

        // R9: disable both, later match must not reset
        wr(8'h28, 0);
        wr(8'h24, 0);
        wr(8'h2C, 32'h3F);
        m = (exp_cnt() + 6) % MOD;
        wr(8'h1C, m);
        watch_match(WD, m, 1'b0);
        repeat (4) begin @(negedge clk); check("R9 disabled", {31'd0, wdog_rst}, 0); end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule